// File: doc/BRIEF.md
# Freezable Decrementer Channel with Timer Event

This block is a down-counting decrementer with its own event logic. Software loads a start value through a load port. The count then drops by one on every timebase tick. Whenever the count borrows past zero, it wraps to all ones and raises a timer event in a small pending-event register. Other event sources set their own pending bits through a set-only vector.

Software clears pending bits by writing an acknowledge word. If that word acknowledges the timer event while the timer event is masked off, the decrementer stops and holds its present count. Only a new load releases it. After each acknowledge the block reports, for one cycle, whether any unmasked event is still pending.

At reset the count starts either at zero or at the bitwise inverse of the low timebase word. A strap input selects which.

Top module: `dec_timer_chan`

## Requirements
- R1: A load (`ld_valid` high) makes `count_o` equal `ld_data` on the next cycle and clears `frozen_o`.
- R2: While not frozen, each cycle with `tick` high lowers `count_o` by one on the next cycle; without a tick the count holds.
- R3: When a load and a tick fall in the same cycle, the loaded value appears undecremented.
- R4: A tick at count zero, not frozen and with no load, gives `0xFFFFFFFF` and sets the timer pending bit, which is bit 5 of `pending_o`, on the next cycle; later ticks keep counting down from there.
- R5: A timer pending bit set by an underflow stays set across a later load.
- R6: An acknowledge (`ack_wr` high) clears each pending bit that is 1 in `ack_data`; a bit set through `ev_set` or by an underflow in the same cycle stays set.
- R7: An acknowledge with `ack_data` bit 5 set while `mask_o` bit 5 is clear freezes the count at the value it held in that cycle (`frozen_o` high). Later ticks leave it unchanged.
- R8: An acknowledge with bit 5 set while `mask_o` bit 5 is set does not freeze the count, and neither does an acknowledge with bit 5 clear.
- R9: While frozen, ticks raise no timer event, and a further freezing acknowledge changes neither the count nor the frozen state.
- R10: During reset `count_o` is `~tb_low` if `sync_init` is high and zero otherwise. `frozen_o`, `pending_o`, `mask_o` and `irq_o` are zero.
- R11: One cycle after an acknowledge, `irq_o` is high for one cycle if the pending bits left after that acknowledge overlap the mask, and low otherwise. Without an acknowledge, `irq_o` is low.
- R12: A mask write shows on `mask_o` on the next cycle. A freeze decision in the same cycle as a mask write uses the mask as it was before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_init | input | 1 | Reset strap: seed the count from the timebase |
| tb_low | input | 32 | Low word of the timebase |
| tick | input | 1 | Timebase tick enable |
| ld_valid | input | 1 | Load strobe |
| ld_data | input | 32 | Value to load |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 8 | New event mask |
| ack_wr | input | 1 | Acknowledge write strobe |
| ack_data | input | 8 | Pending bits to clear |
| ev_set | input | 8 | Set-only pending bits from other sources |
| count_o | output | 32 | Current count (read value) |
| frozen_o | output | 1 | Count is frozen |
| pending_o | output | 8 | Pending event register |
| mask_o | output | 8 | Event mask register |
| irq_o | output | 1 | Interrupt-pending pulse after an acknowledge |

## Verification
Every result of this block is registered. The count, frozen flag, pending bits, mask and interrupt pulse all settle at the first clock edge after the cycle in which the stimulus is driven, so each is due exactly one cycle later. The driver applies one cycle of inputs at the falling edge and queues the outputs it expects after the next rising edge. The monitor compares shortly after that rising edge, which pairs each item with exactly one edge. Corner cases such as a load against a tick, an acknowledge against a set, and a mask write against a freeze are each driven in a single cycle, so the priority shows in the next sample.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_LOAD   = 2'd1,
    CNT_DOWN   = 2'd2,
    CNT_FREEZE = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/dtc_counter.sv
module dtc_counter
  import dtc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_init,
  input  logic [CNT_W-1:0] init_seed,
  input  logic             tick,
  input  logic             ld_valid,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             freeze_req,
  output logic [CNT_W-1:0] count_o,
  output logic             frozen_o,
  output logic             uflow_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  function automatic logic borrows(input logic [CNT_W-1:0] v);
    return (v == '0);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             frz_q;
  cnt_act_e         act;

  always_comb begin
    if (ld_valid)        act = CNT_LOAD;
    else if (frz_q)      act = CNT_HOLD;
    else if (freeze_req) act = CNT_FREEZE;
    else if (tick)       act = CNT_DOWN;
    else                 act = CNT_HOLD;
  end

  assign uflow_o = (act == CNT_DOWN) && borrows(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= sync_init ? ~init_seed : '0;
      frz_q <= 1'b0;
    end else begin
      unique case (act)
        CNT_LOAD:   begin cnt_q <= ld_data; frz_q <= 1'b0; end
        CNT_FREEZE: frz_q <= 1'b1;
        CNT_DOWN:   cnt_q <= step_down(cnt_q);
        default:    ;
      endcase
    end
  end

  assign count_o  = cnt_q;
  assign frozen_o = frz_q;

  assert_load_takes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (cnt_q == $past(ld_data)) && !frz_q);

  assert_frozen_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && !ld_valid) |=> $stable(cnt_q) && frz_q);

  assert_freeze_enters_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_req && !ld_valid) |=> frz_q && (cnt_q == $past(cnt_q)));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uflow_o |=> (cnt_q == ALL_ONES));

  assert_no_event_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q |-> !uflow_o);
endmodule

// File: rtl/dtc_events.sv
module dtc_events #(
  parameter int EV_W   = 8,
  parameter int TM_IDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_wr,
  input  logic [EV_W-1:0] mask_data,
  input  logic            ack_wr,
  input  logic [EV_W-1:0] ack_data,
  input  logic [EV_W-1:0] ev_set,
  input  logic            uflow,
  input  logic            frozen,
  output logic [EV_W-1:0] pend_o,
  output logic [EV_W-1:0] mask_o,
  output logic            irq_o,
  output logic            freeze_req_o
);
  localparam logic [EV_W-1:0] TM_BIT = EV_W'(1) << TM_IDX;

  function automatic logic [EV_W-1:0] clear_then_set(
    input logic [EV_W-1:0] cur, input logic [EV_W-1:0] clr, input logic [EV_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction

  logic [EV_W-1:0] pend_q, mask_q, pend_d, clr_vec, set_vec;
  logic            irq_q;

  assign clr_vec      = ack_wr ? ack_data : '0;
  assign set_vec      = ev_set | (uflow ? TM_BIT : '0);
  assign pend_d       = clear_then_set(pend_q, clr_vec, set_vec);
  assign freeze_req_o = ack_wr && ack_data[TM_IDX] && !mask_q[TM_IDX] && !frozen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (mask_wr) mask_q <= mask_data;
      irq_q  <= ack_wr && (|(pend_d & mask_q));
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> ((pend_q & $past(ack_data) & ~$past(set_vec)) == '0));

  assert_uflow_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |=> pend_q[TM_IDX]);

  assert_irq_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_wr |=> (irq_q == (|(pend_q & $past(mask_q)))));

  assert_irq_needs_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_wr |=> !irq_q);

  assert_mask_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_data)));
endmodule

// File: rtl/dec_timer_chan.sv
module dec_timer_chan #(
  parameter int CNT_W  = 32,
  parameter int EV_W   = 8,
  parameter int TM_IDX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_init,
  input  logic [CNT_W-1:0] tb_low,
  input  logic             tick,
  input  logic             ld_valid,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             mask_wr,
  input  logic [EV_W-1:0]  mask_data,
  input  logic             ack_wr,
  input  logic [EV_W-1:0]  ack_data,
  input  logic [EV_W-1:0]  ev_set,
  output logic [CNT_W-1:0] count_o,
  output logic             frozen_o,
  output logic [EV_W-1:0]  pending_o,
  output logic [EV_W-1:0]  mask_o,
  output logic             irq_o
);
  logic uflow_w;
  logic freeze_req_w;
  logic frozen_w;

  dtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_init  (sync_init),
    .init_seed  (tb_low),
    .tick       (tick),
    .ld_valid   (ld_valid),
    .ld_data    (ld_data),
    .freeze_req (freeze_req_w),
    .count_o    (count_o),
    .frozen_o   (frozen_w),
    .uflow_o    (uflow_w)
  );

  dtc_events #(.EV_W(EV_W), .TM_IDX(TM_IDX)) u_ev (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_wr      (mask_wr),
    .mask_data    (mask_data),
    .ack_wr       (ack_wr),
    .ack_data     (ack_data),
    .ev_set       (ev_set),
    .uflow        (uflow_w),
    .frozen       (frozen_w),
    .pend_o       (pending_o),
    .mask_o       (mask_o),
    .irq_o        (irq_o),
    .freeze_req_o (freeze_req_w)
  );

  assign frozen_o = frozen_w;

  assert_reset_state_R10: assert property (@(posedge clk)
    !rst_n |=> (pending_o == '0) && (mask_o == '0) && !frozen_o && !irq_o);

  assert_pend_kept_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_o[TM_IDX] && ld_valid && !(ack_wr && ack_data[TM_IDX])) |=> pending_o[TM_IDX]);
endmodule

// File: tb/dec_timer_chan_tb.sv
module dec_timer_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n, sync_init, tick, ld_valid, mask_wr, ack_wr;
  logic [31:0] tb_low, ld_data, count_o;
  logic [7:0]  mask_data, ack_data, ev_set, pending_o, mask_o;
  logic        frozen_o, irq_o;

  always #10 clk = ~clk;

  dec_timer_chan u_dut (
    .clk(clk), .rst_n(rst_n), .sync_init(sync_init), .tb_low(tb_low),
    .tick(tick), .ld_valid(ld_valid), .ld_data(ld_data),
    .mask_wr(mask_wr), .mask_data(mask_data), .ack_wr(ack_wr),
    .ack_data(ack_data), .ev_set(ev_set), .count_o(count_o),
    .frozen_o(frozen_o), .pending_o(pending_o), .mask_o(mask_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] cnt;
    logic        frz;
    logic [7:0]  pend;
    logic [7:0]  mask;
    logic        irq;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;

  logic [31:0] m_cnt;
  logic        m_frz, m_irq;
  logic [7:0]  m_pend, m_mask;

  task automatic step(input logic rst, input logic s_init, input logic [31:0] tbl,
                      input logic tk, input logic ld, input logic [31:0] d,
                      input logic mw, input logic [7:0] md,
                      input logic ak, input logic [7:0] ad,
                      input logic [7:0] st, input string tag);
    exp_t e;
    logic uf, fz;
    logic [7:0] np;
    @(negedge clk);
    rst_n = !rst; sync_init = s_init; tb_low = tbl; tick = tk;
    ld_valid = ld; ld_data = d; mask_wr = mw; mask_data = md;
    ack_wr = ak; ack_data = ad; ev_set = st;
    if (rst) begin
      m_cnt = s_init ? ~tbl : 32'h0;
      m_frz = 1'b0; m_pend = 8'h0; m_mask = 8'h0; m_irq = 1'b0;
    end else begin
      uf = tk && !m_frz && !ld && (m_cnt == 32'h0);
      fz = ak && ad[5] && !m_mask[5] && !m_frz;
      np = (m_pend & ~(ak ? ad : 8'h0)) | st | (uf ? 8'h20 : 8'h0);
      m_irq = ak && ((np & m_mask) != 8'h0);
      if (ld) begin
        m_cnt = d; m_frz = 1'b0;
      end else if (fz) begin
        m_frz = 1'b1;
      end else if (tk && !m_frz) begin
        m_cnt = m_cnt - 32'd1;
      end
      m_pend = np;
      if (mw) m_mask = md;
    end
    e.cnt = m_cnt; e.frz = m_frz; e.pend = m_pend; e.mask = m_mask;
    e.irq = m_irq; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input logic tk, input string tag);
    step(0, 0, 0, tk, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic load(input logic tk, input logic [31:0] d, input string tag);
    step(0, 0, 0, tk, 1, d, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic ack(input logic tk, input logic [7:0] ad, input logic [7:0] st, input string tag);
    step(0, 0, 0, tk, 0, 0, 0, 0, 1, ad, st, tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (count_o !== e.cnt || frozen_o !== e.frz || pending_o !== e.pend ||
          mask_o !== e.mask || irq_o !== e.irq) begin
        bad++;
        $display("FAIL %s: got cnt=%h frz=%b pend=%h mask=%h irq=%b, want cnt=%h frz=%b pend=%h mask=%h irq=%b",
                 e.tag, count_o, frozen_o, pending_o, mask_o, irq_o,
                 e.cnt, e.frz, e.pend, e.mask, e.irq);
      end
    end
  end

  logic done = 1'b0;

  initial begin
    #(200000 * 20);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(1, 0, 32'h1234_5678, 0, 0, 0, 0, 0, 0, 0, 0, "R10 reset zero");
    step(1, 1, 32'h1234_5678, 1, 0, 0, 0, 0, 0, 0, 0, "R10 reset seeded");
    idle(0, "R2 no tick holds");
    load(0, 32'd5, "R1 load");
    idle(1, "R2 tick one");
    idle(1, "R2 tick two");
    load(1, 32'd10, "R3 load beats tick");
    load(0, 32'd1, "R1 load one");
    idle(1, "R2 down to zero");
    idle(1, "R4 wrap and event");
    idle(1, "R4 keeps counting");
    load(0, 32'd7, "R5 event kept over load");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h04, "R6 set other bit");
    ack(0, 8'h04, 8'h04, "R6 set beats clear");
    ack(0, 8'h04, 8'h00, "R6 clear bit");
    step(0, 0, 0, 0, 0, 0, 1, 8'h20, 0, 0, 0, "R12 mask write");
    ack(0, 8'h20, 8'h00, "R8 masked ack no freeze");
    idle(1, "R8 still counting");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h24, "R11 raise events");
    ack(0, 8'h04, 8'h00, "R11 irq on leftover");
    idle(0, "R11 irq drops");
    ack(0, 8'h20, 8'h00, "R11 no irq when empty");
    step(0, 0, 0, 0, 0, 0, 1, 8'h00, 0, 0, 0, "R12 mask clear");
    ack(1, 8'h01, 8'h00, "R8 ack without timer bit");
    ack(1, 8'h20, 8'h00, "R7 freeze on ack");
    for (int i = 0; i < 3; i++) idle(1, "R7 frozen under ticks");
    ack(0, 8'h20, 8'h00, "R9 second freeze ack");
    load(0, 32'd0, "R1 load clears freeze");
    ack(0, 8'h20, 8'h00, "R7 freeze at zero");
    for (int i = 0; i < 3; i++) idle(1, "R9 no event while frozen");
    load(0, 32'd2, "R1 reload");
    step(0, 0, 0, 1, 0, 0, 1, 8'h20, 1, 8'h20, 0, "R12 old mask decides");
    load(0, 32'd4, "R1 unfreeze");
    ack(0, 8'h20, 8'h00, "R12 new mask blocks freeze");
    idle(1, "R8 counting after masked ack");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 final hold");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule